// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block chooses which of sixteen DMA channels is serviced next. Each channel raises a bit in a request vector. The arbiter makes a decision only when no channel is in service. It then grants one channel and holds that grant until the transfer engine reports that the service is done. Two arbitration modes can be selected at run time through a mode register:

- **Fixed-priority.** Each channel has its own programmable 4-bit priority register, and the requesting channel with the largest value wins.
- **Round-robin.** The priority values are ignored. A rotating pointer walks the channels downward from 15 to 0 and then wraps back to 15.

The control is a two-state machine. In `ARB_IDLE` no grant is active. The transition `IDLE_TO_SERVE` happens on the first clock edge where any request is present. It registers the winning channel number and raises the grant. In `ARB_SERVE` the grant and channel number are frozen. The transition `SERVE_TO_IDLE` happens on the edge where `svc_done` is high. It drops the grant and moves the round-robin pointer to the channel one below the winner. The next decision can therefore be made on the edge that follows. Priority writes and mode writes are accepted in either state and take effect at the next decision.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `gnt_vld` is 0, `gnt_ch` is 0, the mode is fixed-priority, channel n's priority register holds n, and the round-robin pointer makes channel 15 the first channel examined.
- R2: In fixed-priority mode (mode register 0), the grant goes to the requesting channel whose priority value is numerically largest.
- R3: In fixed-priority mode, when requesting channels share the largest priority value, the lowest-numbered of them wins.
- R4: A cycle with `prio_we` high stores `prio_wdata` into the priority register of channel `prio_idx`, and that value is used from the next decision on.
- R5: In round-robin mode (mode register 1), priorities have no effect. The grant goes to the first requesting channel found by searching downward from the pointer, wrapping from 0 to 15.
- R6: When a grant completes, the pointer becomes the winner's number minus one, with 0 wrapping to 15. The pointer moves at no other time.
- R7: `IDLE_TO_SERVE` raises `gnt_vld` one clock edge after a request is seen in `ARB_IDLE`. While in `ARB_SERVE`, `gnt_vld` and `gnt_ch` stay constant whatever `req` does. `SERVE_TO_IDLE` drops `gnt_vld` on the edge where `svc_done` is high.
- R8: While idle with no request pending, `gnt_vld` stays 0 and `gnt_ch` keeps its last value.
- R9: A cycle with `mode_we` high loads `mode_rr` into the mode register. A change made during service leaves the current grant untouched and applies to the next decision.
- R10: `svc_done` has no effect while no grant is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 16 | Service request, one bit per channel |
| prio_we | input | 1 | Priority register write strobe |
| prio_idx | input | 4 | Channel whose priority is written |
| prio_wdata | input | 4 | Priority value to write |
| mode_we | input | 1 | Mode register write strobe |
| mode_rr | input | 1 | Mode value: 0 fixed-priority, 1 round-robin |
| svc_done | input | 1 | Current service finished |
| gnt_vld | output | 1 | A channel is granted |
| gnt_ch | output | 4 | Granted channel number |

## Verification
Several properties are checked on every cycle by assertions:

- the grant is frozen during service and released by `svc_done`;
- an idle cycle with no request changes nothing;
- a pending request always leads to a grant;
- each selector returns a channel that is actually requesting;
- a priority write lands in the addressed register.

Other behaviour can only be shown by the bench's directed scenarios, which compare the granted channel with hand-computed values:

- which channel wins under given priorities;
- lowest-index tie-breaking;
- the downward round-robin order and its wrap;
- the reset value of the pointer;
- a mode change that is deferred until the next decision.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_SERVE = 1'b1
    } arb_state_e;

    typedef enum logic {
        MODE_FIXED = 1'b0,
        MODE_RR    = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/dma_prio_regs.sv
module dma_prio_regs #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [CH_W-1:0]                widx,
    input  logic [PRIO_W-1:0]              wdata,
    output logic [NUM_CH-1:0][PRIO_W-1:0]  prio
);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic [PRIO_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= PRIO_W'(n);
            end else if (we && (widx == CH_W'(n))) begin
                val_q <= wdata;
            end
        end

        assign prio[n] = val_q;
    end

    AST_PRIO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (prio[$past(widx)] == $past(wdata)))
        else $error("priority write not stored"); // R4

endmodule

// File: rtl/dma_fixed_pick.sv
module dma_fixed_pick #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]              req,
    input  logic [NUM_CH-1:0][PRIO_W-1:0]  prio,
    output logic                           any,
    output logic [CH_W-1:0]                win
);

    logic              found;
    logic [PRIO_W-1:0] best;

    // Ascending scan with a strict compare: a later channel replaces the
    // current best only with a larger value, so ties keep the lower index.
    always_comb begin
        found = 1'b0;
        best  = '0;
        win   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req[i] && (!found || (prio[i] > best))) begin
                found = 1'b1;
                best  = prio[i];
                win   = CH_W'(i);
            end
        end
        any = found;
    end

    always_comb begin
        if (any) begin
            AST_FIX_WIN_REQUESTED: assert (req[win])
                else $error("fixed pick chose an idle channel"); // R2
        end
    end

endmodule

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
    parameter int NUM_CH = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [CH_W-1:0]   start,
    output logic              any,
    output logic [CH_W-1:0]   win
);

    function automatic int step_down(input int s, input int k);
        return (s + NUM_CH - k) % NUM_CH;
    endfunction

    logic found;

    // Descending search beginning at the pointer, wrapping 0 -> NUM_CH-1.
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (!found && req[step_down(int'(start), k)]) begin
                found = 1'b1;
                win   = CH_W'(step_down(int'(start), k));
            end
        end
        any = found;
    end

    always_comb begin
        if (any) begin
            AST_RR_WIN_REQUESTED: assert (req[win])
                else $error("round-robin pick chose an idle channel"); // R5
        end
    end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req,
    input  logic              prio_we,
    input  logic [CH_W-1:0]   prio_idx,
    input  logic [PRIO_W-1:0] prio_wdata,
    input  logic              mode_we,
    input  logic              mode_rr,
    input  logic              svc_done,
    output logic              gnt_vld,
    output logic [CH_W-1:0]   gnt_ch
);

    import dma_arb_pkg::*;

    arb_state_e                    state_q, state_d;
    arb_mode_e                     mode_q;
    logic [CH_W-1:0]               rr_ptr_q;
    logic [NUM_CH-1:0][PRIO_W-1:0] prio;
    logic                          fx_any, rr_any, any_req;
    logic [CH_W-1:0]               fx_win, rr_win, win;

    dma_prio_regs #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (prio_we),
        .widx  (prio_idx),
        .wdata (prio_wdata),
        .prio  (prio)
    );

    dma_fixed_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_fixed (
        .req  (req),
        .prio (prio),
        .any  (fx_any),
        .win  (fx_win)
    );

    dma_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
        .req   (req),
        .start (rr_ptr_q),
        .any   (rr_any),
        .win   (rr_win)
    );

    assign any_req = (mode_q == MODE_RR) ? rr_any : fx_any;
    assign win     = (mode_q == MODE_RR) ? rr_win : fx_win;

    // Next state: IDLE_TO_SERVE on any request, SERVE_TO_IDLE on svc_done.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (any_req)  state_d = ARB_SERVE;
            ARB_SERVE: if (svc_done) state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs, pointer and mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_ch   <= '0;
            rr_ptr_q <= CH_W'(NUM_CH - 1);
            mode_q   <= MODE_FIXED;
        end else begin
            if (mode_we) mode_q <= arb_mode_e'(mode_rr);
            unique case (state_q)
                ARB_IDLE: begin
                    if (any_req) gnt_ch <= win;
                end
                ARB_SERVE: begin
                    if (svc_done) begin
                        rr_ptr_q <= (gnt_ch == '0) ? CH_W'(NUM_CH - 1)
                                                   : gnt_ch - CH_W'(1);
                    end
                end
            endcase
        end
    end

    assign gnt_vld = (state_q == ARB_SERVE);

    always_comb begin
        AST_PICKERS_AGREE: assert (fx_any == rr_any)
            else $error("selectors disagree on request presence"); // R8
    end

    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && !svc_done) |=> (gnt_vld && $stable(gnt_ch)))
        else $error("grant changed during service"); // R7

    AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && svc_done) |=> !gnt_vld)
        else $error("grant not released"); // R7

    AST_IDLE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_vld && (req != '0)) |=> gnt_vld)
        else $error("pending request not granted"); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_vld && (req == '0)) |=> (!gnt_vld && $stable(gnt_ch)))
        else $error("idle arbiter changed output"); // R8

    AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_vld && svc_done && (req == '0)) |=> !gnt_vld)
        else $error("svc_done acted while idle"); // R10

endmodule

// File: tb/dma_req_arbiter_test.sv
module dma_req_arbiter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic        prio_we = 1'b0;
    logic [3:0]  prio_idx = '0;
    logic [3:0]  prio_wdata = '0;
    logic        mode_we = 1'b0;
    logic        mode_rr = 1'b0;
    logic        svc_done = 1'b0;
    logic        gnt_vld;
    logic [3:0]  gnt_ch;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    dma_req_arbiter uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .prio_we    (prio_we),
        .prio_idx   (prio_idx),
        .prio_wdata (prio_wdata),
        .mode_we    (mode_we),
        .mode_rr    (mode_rr),
        .svc_done   (svc_done),
        .gnt_vld    (gnt_vld),
        .gnt_ch     (gnt_ch)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; prio_we = 1'b0; mode_we = 1'b0; svc_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_prio(input int ch, input int val);
        prio_we = 1'b1; prio_idx = 4'(ch); prio_wdata = 4'(val);
        @(negedge clk);
        prio_we = 1'b0;
    endtask

    task automatic write_mode(input bit rr);
        mode_we = 1'b1; mode_rr = rr;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    // Starts idle at a falling edge with req low; ends the same way.
    task automatic grant_cycle(input logic [15:0] r, input int exp, input string tag);
        req = r;
        @(negedge clk);
        chk({tag, " gnt_vld"}, int'(gnt_vld), 1);
        chk({tag, " gnt_ch"}, int'(gnt_ch), exp);
        svc_done = 1'b1; req = '0;
        @(negedge clk);
        svc_done = 1'b0;
        chk({tag, " released"}, int'(gnt_vld), 0);
    endtask

    task automatic t_reset();
        chk("R1 reset gnt_vld", int'(gnt_vld), 0);
        chk("R1 reset gnt_ch", int'(gnt_ch), 0);
        grant_cycle(16'h0028, 5, "R1 priority n reset");
    endtask

    task automatic t_fixed();
        grant_cycle(16'h0012, 4, "R2 two requests");
        grant_cycle(16'hFFFF, 15, "R2 all requests");
        grant_cycle(16'h0001, 0, "R2 single request");
    endtask

    task automatic t_prio_write();
        write_prio(2, 15);
        write_prio(15, 2);
        grant_cycle(16'h8004, 2, "R4 raised ch2");
        grant_cycle(16'h8008, 3, "R4 lowered ch15");
    endtask

    task automatic t_tie();
        write_prio(9, 15);
        grant_cycle(16'h0204, 2, "R3 tie ch2 ch9");
        write_prio(0, 15);
        grant_cycle(16'h0205, 0, "R3 tie ch0 ch2 ch9");
    endtask

    task automatic t_hold();
        req = 16'h0010;
        @(negedge clk);
        chk("R7 grant rises", int'(gnt_vld), 1);
        chk("R7 grant ch4", int'(gnt_ch), 4);
        req = 16'hFFFF;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R7 held vld", int'(gnt_vld), 1);
            chk("R7 held ch", int'(gnt_ch), 4);
        end
        svc_done = 1'b1;
        @(negedge clk);
        svc_done = 1'b0;
        chk("R7 drop after done", int'(gnt_vld), 0);
        @(negedge clk);
        chk("R7 regrant vld", int'(gnt_vld), 1);
        chk("R7 regrant ch", int'(gnt_ch), 0);  // ch0, ch2, ch9 all hold 15
        svc_done = 1'b1; req = '0;
        @(negedge clk);
        svc_done = 1'b0;
    endtask

    task automatic t_idle();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R8 idle vld", int'(gnt_vld), 0);
            chk("R8 idle ch holds", int'(gnt_ch), 0);
        end
        svc_done = 1'b1;
        repeat (2) @(negedge clk);
        svc_done = 1'b0;
        chk("R10 done while idle", int'(gnt_vld), 0);
        grant_cycle(16'h0100, 8, "R10 next grant");
    endtask

    task automatic t_rr();
        apply_reset();
        write_mode(1'b1);
        write_prio(0, 15);
        grant_cycle(16'hFFFF, 15, "R1 pointer reset");
        grant_cycle(16'hFFFF, 14, "R5 descend 14");
        grant_cycle(16'hFFFF, 13, "R5 descend 13");
        grant_cycle(16'h0003, 1, "R5 ignores prio");
        grant_cycle(16'h0003, 0, "R6 step to 0");
        grant_cycle(16'h0003, 1, "R6 wrap 0 to 15");
        grant_cycle(16'h8001, 0, "R6 start below winner");
        grant_cycle(16'h8001, 15, "R6 wrap after 0");
    endtask

    task automatic t_mode_switch();
        // Pointer is now 14: search 14..0 then 15.
        req = 16'h0006;
        @(negedge clk);
        chk("R9 rr grant", int'(gnt_ch), 2);
        write_mode(1'b0);
        chk("R9 grant kept vld", int'(gnt_vld), 1);
        chk("R9 grant kept ch", int'(gnt_ch), 2);
        svc_done = 1'b1; req = '0;
        @(negedge clk);
        svc_done = 1'b0;
        // Round-robin would give 1 (pointer 1); fixed gives 3.
        grant_cycle(16'h000A, 3, "R9 fixed after switch");
    endtask

    initial begin
        apply_reset();
        t_reset();
        t_fixed();
        t_prio_write();
        t_tie();
        t_hold();
        t_idle();
        t_rr();
        t_mode_switch();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule